// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns a sixteen-bit word, pulled serially from a host, into a Manchester II framed word on a complementary pair of line outputs. Each frame takes twenty bit times. The first three bit times carry a sync pattern, which is either a command sync or a data sync. Sixteen Manchester-coded data bits follow, most significant bit first. The last bit time carries an odd parity bit. The core runs from a send clock at twice the bit rate. It divides that clock by two to make a shift clock, which the host uses to pace its serial data.

The host holds the enable input high to request a frame. It answers the data-request strobe by presenting one data bit per shift-clock period. Keeping enable high chains frames with no idle time between them. An active-low inhibit input forces both line outputs high without disturbing the sequencer. A synchronous master reset aborts the frame in progress. A divide-by-six prescaler, clocked from its own input, is provided so that a faster clock can be divided down to the send clock.

Top module: `mce_encoder`

## Requirements
- R1: While no frame is in progress, both line outputs and the data-request strobe are low. The shift clock is low after reset and inverts on every rising send-clock edge.
- R2: A frame starts on a send-clock edge at which enable is high and the shift clock is high. The one-output shows the first half-bit after the next send-clock edge, and the frame occupies 40 send-clock periods.
- R3: Sync select is sampled only on the send-clock edge that follows the frame start. A value of 1 gives a command sync, in which the one-output is high for three half-bits and then low for three. A value of 0 gives the opposite levels.
- R4: The data-request strobe is high for 32 send-clock periods, from 4 to 35 periods after the start edge. Serial data is taken on the edges that fall 6, 8, …, 36 periods after the start edge, in the order bit 15 down to bit 0.
- R5: Each data bit takes one bit time after the sync. On the one-output, a 1 is sent as high then low and a 0 as low then high.
- R6: The final bit time carries a parity bit that makes the number of ones across the 16 data bits and the parity bit odd. It is Manchester-coded in the same way as a data bit.
- R7: During a frame, with inhibit released, the zero-output is always the complement of the one-output.
- R8: If enable is high at the last half-bit edge, the next frame's sync follows immediately with no gap. If enable is low, the outputs return to idle.
- R9: While inhibit is low, both line outputs are high in the same cycle. The frame timing, the data sampling and the data-request strobe are not affected.
- R10: Master reset is taken on a rising send-clock edge. It aborts any frame, forces the outputs idle and clears the shift clock, and a new frame can follow.
- R11: The prescaler output has a period of six prescaler-clock cycles. It is high for the first three cycles after reset and low for the next three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_clk | input | 1 | Prescaler clock |
| div6_out | output | 1 | Prescaler output, input clock divided by six |
| send_clk | input | 1 | Send clock, twice the bit rate |
| mst_rst | input | 1 | Synchronous master reset, active high |
| enable | input | 1 | Frame request |
| sync_sel | input | 1 | 1 = command sync, 0 = data sync |
| ser_data | input | 1 | Serial data from host |
| inhibit_n | input | 1 | Output inhibit, active low |
| data_req | output | 1 | Data-request strobe to host |
| shift_clk | output | 1 | Shift clock, one period per bit time |
| line_pos | output | 1 | Bipolar one-output |
| line_neg | output | 1 | Bipolar zero-output |

## Verification
The frame path is driven with every single-one word and every single-zero word, with the sync type alternating between frames, and then with all-zeros, all-ones and the two alternating-bit words. The one-hot and one-cold words show whether each bit position reaches its own bit time in most-significant-first order, and whether the parity bit changes with each bit. The alternating words and the constant words separate a missing mid-bit transition from a wrong polarity. A run of four chained frames with mixed sync types shows whether frames follow each other without a gap and whether sync select is sampled in each frame. An inhibit pulse inside a frame and an abort partway through a frame are both followed by a fresh frame, which shows that inhibit leaves the sequencer untouched and that reset clears it.

// File: rtl/mce_pkg.sv
package mce_pkg;

   // Half-bit slots spent on the sync pattern (three bit times).
   localparam int unsigned SYNC_HALVES = 6;

   // Level of the one-output during sync half-bit "half".
   // A command sync is high first, a data sync is low first.
   function automatic logic sync_level(input logic cmd, input int unsigned half);
      return (half < SYNC_HALVES / 2) ? cmd : ~cmd;
   endfunction

endpackage

// File: rtl/mce_prescaler.sv
module mce_prescaler #(
   parameter int unsigned DIV = 6
) (
   input  logic clk,
   input  logic rst,
   output logic div_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] TOP_C  = PW'(DIV - 1);
   localparam logic [PW-1:0] HALF_C = PW'(DIV / 2);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("mce_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == TOP_C) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign div_o = (cnt_q < HALF_C);

   // R11: the divider count never leaves its modulus
   a_r11_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= TOP_C);

endmodule

// File: rtl/mce_sequencer.sv
module mce_sequencer #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CW     = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          enable,
   input  logic          sync_sel,
   output logic          sclk_o,
   output logic          busy_o,
   output logic [CW-1:0] cnt_o,
   output logic          cmd_o,
   output logic          take_bit_o,
   output logic          req_o
);
   import mce_pkg::*;

   localparam int unsigned PAR_H   = SYNC_HALVES + 2 * DATA_W;
   localparam int unsigned FRAME_H = PAR_H + 2;
   localparam logic [CW-1:0] LAST_C   = CW'(FRAME_H - 1);
   localparam logic [CW-1:0] REQ_LO_C = CW'(SYNC_HALVES - 2);
   localparam logic [CW-1:0] REQ_HI_C = CW'(PAR_H - 3);
   localparam logic [CW-1:0] TAK_LO_C = CW'(SYNC_HALVES - 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mce_sequencer: DATA_W must be at least 1");
      end
      if ((1 << CW) < FRAME_H) begin : g_bad_cw
         $error("mce_sequencer: CW too narrow for the frame");
      end
   endgenerate

   logic          sclk_q;
   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic          cmd_q;
   logic          at_last;
   logic          start;

   assign at_last = busy_q && (cnt_q == LAST_C);
   // A frame starts on a falling shift-clock edge, from idle or at the frame end.
   assign start   = sclk_q && enable && (!busy_q || at_last);

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
         cmd_q  <= 1'b0;
      end else begin
         sclk_q <= ~sclk_q;
         if (busy_q && (cnt_q == '0)) begin
            cmd_q <= sync_sel;
         end
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (at_last) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sclk_o     = sclk_q;
   assign busy_o     = busy_q;
   assign cnt_o      = cnt_q;
   assign cmd_o      = (cnt_q == '0) ? sync_sel : cmd_q;
   assign take_bit_o = busy_q && cnt_q[0] && (cnt_q >= TAK_LO_C) && (cnt_q <= REQ_HI_C);
   assign req_o      = busy_q && (cnt_q >= REQ_LO_C) && (cnt_q <= REQ_HI_C);

   // R8: enable held at the last half-bit chains the next frame without a gap
   a_r8_gapless: assert property (@(posedge clk) disable iff (rst)
      (at_last && enable) |=> (busy_q && cnt_q == '0));

   // R8: enable low at the last half-bit returns the sequencer to idle
   a_r8_stop: assert property (@(posedge clk) disable iff (rst)
      (at_last && !enable) |=> !busy_q);

   // R2: the half-bit counter stays inside one frame
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (cnt_q <= LAST_C));

endmodule

// File: rtl/mce_shaper.sv
module mce_shaper #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CW         = 6,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          busy_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          cmd_i,
   input  logic          take_bit_i,
   input  logic          ser_data,
   output logic          line_o,
   output logic          act_o
);
   import mce_pkg::*;

   localparam int unsigned PAR_H   = SYNC_HALVES + 2 * DATA_W;
   localparam int unsigned FRAME_H = PAR_H + 2;
   localparam logic [CW-1:0] SYNC_C  = CW'(SYNC_HALVES);
   localparam logic [CW-1:0] PAR_C   = CW'(PAR_H);
   localparam logic [CW-1:0] FRAME_C = CW'(FRAME_H);

   logic par_init;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_init = 1'b1;
      end else begin : g_even
         assign par_init = 1'b0;
      end
   endgenerate

   logic line_q;
   logic act_q;
   logic cur_q;
   logic par_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q <= 1'b0;
         act_q  <= 1'b0;
         cur_q  <= 1'b0;
         par_q  <= 1'b0;
      end else begin
         act_q <= busy_i;
         if (busy_i && (cnt_i == '0)) begin
            par_q <= par_init;
         end else if (take_bit_i) begin
            par_q <= par_q ^ ser_data;
         end
         if (take_bit_i) begin
            cur_q <= ser_data;
         end
         if (busy_i) begin
            if (cnt_i < SYNC_C) begin
               line_q <= sync_level(cmd_i, int'(cnt_i));
            end else if (cnt_i < PAR_C) begin
               line_q <= cnt_i[0] ? ~cur_q : cur_q;
            end else begin
               line_q <= cnt_i[0] ? ~par_q : par_q;
            end
         end
      end
   end

   assign line_o = line_q;
   assign act_o  = act_q;

   // R5: every data or parity bit flips the line at mid-bit
   a_r5_mid_bit_flip: assert property (@(posedge clk) disable iff (rst)
      (busy_i && cnt_i[0] && cnt_i > SYNC_C && cnt_i < FRAME_C)
      |=> (line_q != $past(line_q)));

endmodule

// File: rtl/mce_encoder.sv
module mce_encoder #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned PRE_DIV    = 6,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic enc_clk,
   output logic div6_out,
   input  logic send_clk,
   input  logic mst_rst,
   input  logic enable,
   input  logic sync_sel,
   input  logic ser_data,
   input  logic inhibit_n,
   output logic data_req,
   output logic shift_clk,
   output logic line_pos,
   output logic line_neg
);
   localparam int unsigned FRAME_H = mce_pkg::SYNC_HALVES + 2 * DATA_W + 2;
   localparam int unsigned CW      = $clog2(FRAME_H + 1);

   logic          busy;
   logic [CW-1:0] cnt;
   logic          cmd;
   logic          take_bit;
   logic          line;
   logic          act;

   mce_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk   (enc_clk),
      .rst   (mst_rst),
      .div_o (div6_out)
   );

   mce_sequencer #(.DATA_W(DATA_W), .CW(CW)) u_seq (
      .clk        (send_clk),
      .rst        (mst_rst),
      .enable     (enable),
      .sync_sel   (sync_sel),
      .sclk_o     (shift_clk),
      .busy_o     (busy),
      .cnt_o      (cnt),
      .cmd_o      (cmd),
      .take_bit_o (take_bit),
      .req_o      (data_req)
   );

   mce_shaper #(.DATA_W(DATA_W), .CW(CW), .ODD_PARITY(ODD_PARITY)) u_shp (
      .clk        (send_clk),
      .rst        (mst_rst),
      .busy_i     (busy),
      .cnt_i      (cnt),
      .cmd_i      (cmd),
      .take_bit_i (take_bit),
      .ser_data   (ser_data),
      .line_o     (line),
      .act_o      (act)
   );

   assign line_pos = !inhibit_n ? 1'b1 : (act & line);
   assign line_neg = !inhibit_n ? 1'b1 : (act & ~line);

endmodule

// File: tb/mce_encoder_tb.sv
`timescale 1ns/1ps
module mce_encoder_tb_top;

   logic clk = 1'b0;
   logic mst_rst = 1'b1;
   logic enable = 1'b0;
   logic sync_sel = 1'b0;
   logic ser_data = 1'b0;
   logic inhibit_n = 1'b1;
   logic div6_out, data_req, shift_clk, line_pos, line_neg;

   always #2.5 clk = ~clk;

   mce_encoder dut_i (
      .enc_clk   (clk),
      .div6_out  (div6_out),
      .send_clk  (clk),
      .mst_rst   (mst_rst),
      .enable    (enable),
      .sync_sel  (sync_sel),
      .ser_data  (ser_data),
      .inhibit_n (inhibit_n),
      .data_req  (data_req),
      .shift_clk (shift_clk),
      .line_pos  (line_pos),
      .line_neg  (line_neg)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit mon_on = 0;
   int abort_edge = -100;

   // Scheduled frames: start edge, word, sync type, gapless flag, cutoff edge.
   int          t0_a [64];
   logic [15:0] w_a  [64];
   logic        c_a  [64];
   bit          bb_a [64];
   int          ab_a [64];
   int          nfr = 0;

   logic [15:0] seq_w [8];
   logic        seq_c [8];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   function automatic logic half_val(input logic [15:0] w, input logic cmd, input int h);
      logic b;
      if (h < 6) return cmd ? (h < 3) : (h >= 3);
      if (h < 38) begin
         b = w[15 - (h - 6) / 2];
         return (((h - 6) % 2) == 0) ? b : ~b;
      end
      b = ~(^w);
      return (h == 38) ? b : ~b;
   endfunction

   function automatic string region_tag(input int h, input bit bb);
      if (h == 0) return bb ? "R8" : "R2";
      if (h < 6) return "R3";
      if (h < 38) return "R5";
      return "R6";
   endfunction

   // Output monitor, sampled on the falling send-clock edge.
   always @(negedge clk) begin
      if (mon_on) begin
         logic ex_p, ex_req, in_fr;
         string tg;
         int h, k;
         in_fr = 0; ex_req = 0; ex_p = 0; tg = "R1";
         for (int f = 0; f < nfr; f++) begin
            if (cyc < ab_a[f]) begin
               h = cyc - t0_a[f] - 1;
               k = cyc - t0_a[f];
               if (h >= 0 && h < 40) begin
                  in_fr = 1;
                  ex_p = half_val(w_a[f], c_a[f], h);
                  tg = region_tag(h, bb_a[f]);
               end
               if (k >= 4 && k <= 35) ex_req = 1;
            end
         end
         if (!in_fr && cyc >= abort_edge && cyc < abort_edge + 4) tg = "R10";
         if (!inhibit_n) begin
            chk(line_pos && line_neg, "R9", {line_pos, line_neg}, 3);
         end else if (in_fr) begin
            chk(line_pos == ex_p, tg, line_pos, ex_p);
            chk(line_neg == ~line_pos, "R7", line_neg, ~line_pos);
         end else begin
            chk(!line_pos && !line_neg, tg, {line_pos, line_neg}, 0);
         end
         chk(data_req == ex_req, "R4", data_req, ex_req);
      end
   end

   // Host: answers the data-request strobe, one bit per shift-clock period.
   int hw = 0;
   int hn = 0;
   always @(negedge clk) begin
      #1;
      if (data_req) begin
         if (hn < 32 && hw < nfr) ser_data = w_a[hw][15 - hn / 2];
         hn++;
      end else if (hn > 0) begin
         hn = 0;
         hw++;
      end
   end

   task automatic run_seq(input int nf);
      int t0, f;
      do @(negedge clk); while (shift_clk !== 1'b1);
      #1;
      enable = 1'b1;
      sync_sel = seq_c[0];
      t0 = cyc + 1;
      for (int i = 0; i < nf; i++) begin
         t0_a[nfr] = t0 + 40 * i;
         w_a[nfr]  = seq_w[i];
         c_a[nfr]  = seq_c[i];
         bb_a[nfr] = (i > 0);
         ab_a[nfr] = 1 << 30;
         nfr++;
      end
      while (cyc < t0 + 40 * nf + 4) begin
         @(negedge clk);
         #1;
         f = (cyc - t0) / 40;
         if (f > nf - 1) f = nf - 1;
         sync_sel = (((cyc - t0) % 40) == 0) ? seq_c[f] : ~seq_c[f];
         if (cyc == t0 + 40 * (nf - 1) + 1) enable = 1'b0;
      end
   endtask

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state, R11 prescaler reset phase
      chk(!line_pos && !line_neg, "R1", {line_pos, line_neg}, 0);
      chk(!data_req, "R1", data_req, 0);
      chk(!shift_clk, "R1", shift_clk, 0);
      chk(div6_out, "R11", div6_out, 1);
      #1 mst_rst = 1'b0;
      for (int i = 1; i <= 24; i++) begin
         @(negedge clk);
         chk(div6_out == ((i % 6) < 3), "R11", div6_out, (i % 6) < 3);
         chk(shift_clk == (i % 2), "R1", shift_clk, i % 2);
      end
      mon_on = 1;

      // One-hot and one-cold words, alternating sync type
      for (int i = 0; i < 16; i++) begin
         seq_w[0] = 16'(1 << i); seq_c[0] = i[0];
         run_seq(1);
         seq_w[0] = ~16'(1 << i); seq_c[0] = ~i[0];
         run_seq(1);
      end
      // Constant and alternating words
      seq_w[0] = 16'h0000; seq_c[0] = 1'b1; run_seq(1);
      seq_w[0] = 16'hFFFF; seq_c[0] = 1'b0; run_seq(1);
      seq_w[0] = 16'hAAAA; seq_c[0] = 1'b1; run_seq(1);
      seq_w[0] = 16'h5555; seq_c[0] = 1'b0; run_seq(1);

      // R8: four chained frames
      seq_w[0] = 16'h1234; seq_c[0] = 1'b1;
      seq_w[1] = 16'h8001; seq_c[1] = 1'b0;
      seq_w[2] = 16'hFFFE; seq_c[2] = 1'b0;
      seq_w[3] = 16'h0000; seq_c[3] = 1'b1;
      run_seq(4);

      // R9: inhibit inside a frame, then while idle
      seq_w[0] = 16'hC3A5; seq_c[0] = 1'b1;
      fork
         run_seq(1);
         begin
            repeat (20) @(negedge clk);
            #1 inhibit_n = 1'b0;
            repeat (9) @(negedge clk);
            #1 inhibit_n = 1'b1;
         end
      join
      @(negedge clk); #1 inhibit_n = 1'b0;
      repeat (4) @(negedge clk);
      #1 inhibit_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10: abort partway through a frame, then a fresh frame
      seq_w[0] = 16'h0F0F; seq_c[0] = 1'b0;
      fork
         run_seq(1);
         begin
            repeat (20) @(negedge clk);
            #1;
            mst_rst = 1'b1;
            abort_edge = cyc + 1;
            ab_a[nfr - 1] = cyc + 1;
            @(negedge clk);
            chk(!shift_clk, "R10", shift_clk, 0);
            chk(!data_req, "R10", data_req, 0);
            #1 mst_rst = 1'b0;
         end
      join
      seq_w[0] = 16'h7E81; seq_c[0] = 1'b1; run_seq(1);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule